// File: doc/BRIEF.md
# Segment Access-Mode Address Classifier

This block decides how a 32-bit virtual address is handled before any page-table lookup. The address space is split into six fixed segments: two of 1 GiB at the bottom and four of 512 MiB above them. Each segment has a 16-bit descriptor. The descriptor carries a 3-bit access-mode code, an error-level override bit, a physical base field and a cache attribute. Three 32-bit configuration words hold two descriptors each.

For each request the block picks the descriptor that covers the address. It then checks the access-mode code against the current privilege level and returns one of three results:

- an address error;
- a request for a TLB lookup;
- an unmapped translation, with a physical address and full read/write permission.

The result is registered and appears, with a valid strobe, one cycle after the request. A core's load/store unit uses it in front of its TLB. The TLB-request output tells that unit when a lookup is required.

Top module: `segacc_classifier`

## Requirements
- R1: While `rst` is high, and after it is released, until the first request, `rsp_valid` and `tlb_req` are 0, `rsp_status` is 00 and `rsp_paddr` is 0.
- R2: A request sampled on `req_valid` at a rising clock edge produces exactly one response, with `rsp_valid` high, in the following cycle. `rsp_status` is coded 00 = unmapped, 01 = TLB lookup needed, 10 = address error, and never reads 11 while valid.
- R3: Descriptor selection, with the upper half meaning bits [31:16] and the lower half bits [15:0]:
  - below 0x40000000 uses the upper half of `seg_cfg2`;
  - 0x40000000–0x7FFFFFFF uses the lower half of `seg_cfg2`;
  - 0x80000000–0x9FFFFFFF uses the upper half of `seg_cfg1`;
  - 0xA0000000–0xBFFFFFFF uses the lower half of `seg_cfg1`;
  - 0xC0000000–0xDFFFFFFF uses the upper half of `seg_cfg0`;
  - 0xE0000000 and above uses the lower half of `seg_cfg0`.

  Within a half, the physical base field is bits [15:9], the access mode is bits [6:4], the override bit is bit [3] and the cache attribute is bits [2:0]. Bits [8:7] are ignored.
- R4: Kernel privilege (`req_priv` = 0): modes 1, 2 and 3 need a TLB lookup. Modes 0, 4, 5 and 7 are unmapped.
- R5: Supervisor privilege (`req_priv` = 1): modes 0 and 1 are address errors, modes 2, 3 and 4 need a TLB lookup, and modes 5 and 7 are unmapped.
- R6: User privilege (`req_priv` = 2): modes 0, 1, 2 and 5 are address errors, modes 3 and 4 need a TLB lookup, and mode 7 is unmapped.
- R7: Error-level privilege (`req_priv` = 3): when the descriptor's override bit is 1, the result is unmapped for every mode. When the bit is 0, the kernel rules apply.
- R8: Mode 6 is an address error at every privilege level. The only exception is error level with the override bit set.
- R9: An unmapped result gives a 36-bit physical address:
  - in the two 1 GiB segments, `{base[6:1], vaddr[29:0]}`;
  - in the 512 MiB segments, `{base[6:0], vaddr[28:0]}`.
- R10: `rsp_rd_ok` and `rsp_wr_ok` are 1 exactly for unmapped results. For the other results `rsp_paddr` is 0.
- R11: `tlb_req` is high for one cycle, together with `rsp_valid`, exactly when the result is 01.
- R12: `rsp_cca` returns the selected descriptor's cache attribute, one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_priv | input | 2 | Privilege: 0 kernel, 1 supervisor, 2 user, 3 error level |
| seg_cfg0 | input | 32 | Descriptors for 0xC0000000 and up |
| seg_cfg1 | input | 32 | Descriptors for 0x80000000–0xBFFFFFFF |
| seg_cfg2 | input | 32 | Descriptors for 0x00000000–0x7FFFFFFF |
| rsp_valid | output | 1 | Result valid |
| rsp_status | output | 2 | Result code |
| rsp_paddr | output | 36 | Physical address for unmapped results |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |
| rsp_cca | output | 3 | Cache attribute of the selected descriptor |
| tlb_req | output | 1 | TLB lookup required |

## Verification
Every result, including the TLB strobe, the permission bits and the cache attribute, is due one rising edge after the request is sampled. The driver applies a request at a falling edge and records the edge count with the expected item. The monitor samples at the next falling edge and checks that exactly one edge has passed before it compares. Requests are issued back to back, so a late or missing response shows up as a count mismatch or as a response with no queued item.

// File: rtl/segacc_pkg.sv
package segacc_pkg;
  localparam int VA_W         = 32;
  localparam int CFG_W        = 32;
  localparam int DESC_W       = 16;
  localparam int NUM_CFG      = 3;
  localparam int NUM_SEG      = 2 * NUM_CFG;
  localparam int PA_FLD_W     = 7;
  localparam int AM_W         = 3;
  localparam int CCA_W        = 3;
  localparam int PA_SHIFT     = 29;
  localparam int PADDR_W      = PA_FLD_W + PA_SHIFT;
  localparam int WIDE_OFS_W   = 30;
  localparam int NARROW_OFS_W = 29;
  localparam int NUM_AM       = 1 << AM_W;

  typedef struct packed {
    logic [PA_FLD_W-1:0] pa;
    logic [1:0]          rsvd;
    logic [AM_W-1:0]     am;
    logic                eu;
    logic [CCA_W-1:0]    cca;
  } seg_desc_t;

  typedef enum logic [1:0] {
    ST_UNMAPPED = 2'b00,
    ST_TLB      = 2'b01,
    ST_ADDR_ERR = 2'b10
  } seg_status_e;

  typedef enum logic [1:0] {
    PRIV_KERNEL = 2'd0,
    PRIV_SUPER  = 2'd1,
    PRIV_USER   = 2'd2,
    PRIV_ERL    = 2'd3
  } priv_e;

  // bit n set => access mode n is in the set
  localparam logic [NUM_AM-1:0] RSVD_SET  = 8'b0100_0000;
  localparam logic [NUM_AM-1:0] K_MAP_SET = 8'b0000_1110;
  localparam logic [NUM_AM-1:0] S_ERR_SET = 8'b0100_0011;
  localparam logic [NUM_AM-1:0] S_MAP_SET = 8'b0001_1100;
  localparam logic [NUM_AM-1:0] U_ERR_SET = 8'b0110_0111;
  localparam logic [NUM_AM-1:0] U_MAP_SET = 8'b0001_1000;
endpackage

// File: rtl/segacc_select.sv
module segacc_select
  import segacc_pkg::*;
(
  input  logic [NUM_CFG*CFG_W-1:0] cfg_flat,
  input  logic [2:0]               va_top,
  output seg_desc_t                desc,
  output logic                     wide
);
  // halves[2*r] = lower half of word r, halves[2*r+1] = upper half
  seg_desc_t halves [NUM_SEG];

  genvar r, h;
  generate
    for (r = 0; r < NUM_CFG; r++) begin : g_word
      for (h = 0; h < 2; h++) begin : g_half
        assign halves[2*r+h] = seg_desc_t'(cfg_flat[r*CFG_W + h*DESC_W +: DESC_W]);
      end
    end
  endgenerate

  logic [$clog2(NUM_SEG)-1:0] idx;

  always_comb begin
    if (!va_top[2]) begin
      idx = va_top[1] ? 3'd4 : 3'd5;       // word 2: lower above 1 GiB, upper below
    end else begin
      unique case (va_top[1:0])
        2'b00:   idx = 3'd3;               // word 1 upper
        2'b01:   idx = 3'd2;               // word 1 lower
        2'b10:   idx = 3'd1;               // word 0 upper
        default: idx = 3'd0;               // word 0 lower
      endcase
    end
  end

  assign desc = halves[idx];
  assign wide = ~va_top[2];
endmodule

// File: rtl/segacc_mode_decode.sv
module segacc_mode_decode
  import segacc_pkg::*;
(
  input  priv_e           priv,
  input  logic [AM_W-1:0] am,
  input  logic            eu,
  output seg_status_e     status
);
  logic [NUM_AM-1:0] err_set;
  logic [NUM_AM-1:0] map_set;

  always_comb begin
    unique case (priv)
      PRIV_SUPER: begin err_set = S_ERR_SET; map_set = S_MAP_SET; end
      PRIV_USER:  begin err_set = U_ERR_SET; map_set = U_MAP_SET; end
      default:    begin err_set = RSVD_SET;  map_set = K_MAP_SET; end
    endcase

    if (priv == PRIV_ERL && eu) begin
      status = ST_UNMAPPED;
    end else if (err_set[am]) begin
      status = ST_ADDR_ERR;
    end else if (map_set[am]) begin
      status = ST_TLB;
    end else begin
      status = ST_UNMAPPED;
    end
  end
endmodule

// File: rtl/segacc_phys.sv
module segacc_phys
  import segacc_pkg::*;
(
  input  logic [PA_FLD_W-1:0]   pa,
  input  logic [WIDE_OFS_W-1:0] va_ofs,
  input  logic                  wide,
  output logic [PADDR_W-1:0]    paddr
);
  localparam logic [PADDR_W-1:0] WIDE_MASK   = {{(PADDR_W-WIDE_OFS_W){1'b0}},   {WIDE_OFS_W{1'b1}}};
  localparam logic [PADDR_W-1:0] NARROW_MASK = {{(PADDR_W-NARROW_OFS_W){1'b0}}, {NARROW_OFS_W{1'b1}}};

  logic [PADDR_W-1:0] ofs_mask;
  logic [PADDR_W-1:0] base;
  logic [PADDR_W-1:0] ofs_ext;

  assign ofs_mask = wide ? WIDE_MASK : NARROW_MASK;
  assign base     = {pa, {PA_SHIFT{1'b0}}};
  assign ofs_ext  = {{(PADDR_W-WIDE_OFS_W){1'b0}}, va_ofs};
  assign paddr    = (base & ~ofs_mask) | (ofs_ext & ofs_mask);
endmodule

// File: rtl/segacc_classifier.sv
module segacc_classifier
  import segacc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [1:0]         req_priv,
  input  logic [CFG_W-1:0]   seg_cfg0,
  input  logic [CFG_W-1:0]   seg_cfg1,
  input  logic [CFG_W-1:0]   seg_cfg2,
  output logic               rsp_valid,
  output logic [1:0]         rsp_status,
  output logic [PADDR_W-1:0] rsp_paddr,
  output logic               rsp_rd_ok,
  output logic               rsp_wr_ok,
  output logic [CCA_W-1:0]   rsp_cca,
  output logic               tlb_req
);
  seg_desc_t          sel_desc;
  logic               sel_wide;
  seg_status_e        cur_status;
  logic [PADDR_W-1:0] cur_paddr;
  logic               unused_rsvd;

  assign unused_rsvd = ^sel_desc.rsvd;

  segacc_select u_select (
    .cfg_flat (  {seg_cfg2, seg_cfg1, seg_cfg0}),
    .va_top   (req_vaddr[VA_W-1:VA_W-3]),
    .desc     (sel_desc),
    .wide     (sel_wide)
  );

  segacc_mode_decode u_decode (
    .priv   (priv_e'(req_priv)),
    .am     (sel_desc.am),
    .eu     (sel_desc.eu),
    .status (cur_status)
  );

  segacc_phys u_phys (
    .pa     (sel_desc.pa),
    .va_ofs (req_vaddr[WIDE_OFS_W-1:0]),
    .wide   (sel_wide),
    .paddr  (cur_paddr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_UNMAPPED;
      rsp_paddr  <= '0;
      rsp_rd_ok  <= 1'b0;
      rsp_wr_ok  <= 1'b0;
      rsp_cca    <= '0;
      tlb_req    <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      tlb_req   <= req_valid && (cur_status == ST_TLB);
      if (req_valid) begin
        rsp_status <= cur_status;
        rsp_paddr  <= (cur_status == ST_UNMAPPED) ? cur_paddr : '0;
        rsp_rd_ok  <= (cur_status == ST_UNMAPPED);
        rsp_wr_ok  <= (cur_status == ST_UNMAPPED);
        rsp_cca    <= sel_desc.cca;
      end
    end
  end
endmodule

// File: rtl/segacc_classifier_chk.sv
module segacc_classifier_chk
  import segacc_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               rsp_valid,
  input logic [1:0]         rsp_status,
  input logic [PADDR_W-1:0] rsp_paddr,
  input logic               rsp_rd_ok,
  input logic               rsp_wr_ok,
  input logic               tlb_req
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !tlb_req && rsp_status == 2'b00 && rsp_paddr == '0));

  assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (rsp_valid == $past(req_valid)));

  assert_status_legal_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_status != 2'b11));

  assert_perm_unmapped_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ((rsp_rd_ok == (rsp_status == 2'b00)) && (rsp_wr_ok == rsp_rd_ok)));

  assert_paddr_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != 2'b00) |-> (rsp_paddr == '0));

  assert_tlb_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    tlb_req == (rsp_valid && rsp_status == 2'b01));
endmodule

bind segacc_classifier segacc_classifier_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .rsp_paddr  (rsp_paddr),
  .rsp_rd_ok  (rsp_rd_ok),
  .rsp_wr_ok  (rsp_wr_ok),
  .tlb_req    (tlb_req)
);

// File: tb/test_segacc_classifier.sv
module test_segacc_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_priv;
  logic [31:0] seg_cfg0, seg_cfg1, seg_cfg2;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [35:0] rsp_paddr;
  logic        rsp_rd_ok, rsp_wr_ok;
  logic [2:0]  rsp_cca;
  logic        tlb_req;

  segacc_classifier i_segacc_classifier (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_priv(req_priv), .seg_cfg0(seg_cfg0), .seg_cfg1(seg_cfg1), .seg_cfg2(seg_cfg2),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_paddr(rsp_paddr),
    .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok), .rsp_cca(rsp_cca), .tlb_req(tlb_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  logic [1:0]  q_st[$];
  logic [35:0] q_pa[$];
  logic [2:0]  q_cca[$];
  int          q_cyc[$];
  string       q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // descriptor: base[15:9], ignored [8:7] set, mode [6:4], override [3], cache [2:0]
  function automatic logic [15:0] mk(input logic [6:0] pa, input logic [2:0] am,
                                     input logic eu, input logic [2:0] cca);
    return {pa, 2'b11, am, eu, cca};
  endfunction

  function automatic logic [15:0] pick(input logic [31:0] va, input logic [31:0] c0,
                                       input logic [31:0] c1, input logic [31:0] c2);
    if (va < 32'h4000_0000)      return c2[31:16];
    else if (va < 32'h8000_0000) return c2[15:0];
    else if (va < 32'hA000_0000) return c1[31:16];
    else if (va < 32'hC000_0000) return c1[15:0];
    else if (va < 32'hE000_0000) return c0[31:16];
    else                         return c0[15:0];
  endfunction

  function automatic logic [1:0] model(input logic [1:0] priv, input logic [2:0] am, input logic eu);
    if (priv == 2'd3 && eu) return 2'b00;
    if (am == 3'd6) return 2'b10;
    case (priv)
      2'd1: begin
        if (am == 0 || am == 1) return 2'b10;
        if (am == 2 || am == 3 || am == 4) return 2'b01;
        return 2'b00;
      end
      2'd2: begin
        if (am == 0 || am == 1 || am == 2 || am == 5) return 2'b10;
        if (am == 3 || am == 4) return 2'b01;
        return 2'b00;
      end
      default: begin
        if (am == 1 || am == 2 || am == 3) return 2'b01;
        return 2'b00;
      end
    endcase
  endfunction

  task automatic send(input logic [1:0] priv, input logic [31:0] va, input logic [31:0] c0,
                      input logic [31:0] c1, input logic [31:0] c2, input string tag);
    logic [15:0] d;
    logic [1:0]  st;
    logic [35:0] pa;
    d  = pick(va, c0, c1, c2);
    st = model(priv, d[6:4], d[3]);
    if (st != 2'b00)     pa = '0;
    else if (!va[31])    pa = {d[15:10], va[29:0]};
    else                 pa = {d[15:9], va[28:0]};
    req_valid = 1'b1; req_vaddr = va; req_priv = priv;
    seg_cfg0 = c0; seg_cfg1 = c1; seg_cfg2 = c2;
    q_st.push_back(st); q_pa.push_back(pa); q_cca.push_back(d[2:0]);
    q_cyc.push_back(cyc); q_tag.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q_st.size() == 0) begin
        chk(1'b0, "R2", "response with nothing queued", 64'(rsp_status), 64'hx);
      end else begin
        logic [1:0]  est;
        logic [35:0] epa;
        logic [2:0]  ecca;
        int          ecyc;
        string       tg;
        est = q_st.pop_front(); epa = q_pa.pop_front(); ecca = q_cca.pop_front();
        ecyc = q_cyc.pop_front(); tg = q_tag.pop_front();
        chk(cyc == ecyc + 1, "R2", "latency edge count", 64'(cyc), 64'(ecyc + 1));
        chk(rsp_status == est, tg, "status", 64'(rsp_status), 64'(est));
        chk(rsp_paddr == epa, (est == 2'b00) ? "R9" : "R10", "paddr", 64'(rsp_paddr), 64'(epa));
        chk(rsp_rd_ok == (est == 2'b00) && rsp_wr_ok == (est == 2'b00), "R10", "rd/wr",
            64'({rsp_rd_ok, rsp_wr_ok}), 64'({2{est == 2'b00}}));
        chk(tlb_req == (est == 2'b01), "R11", "tlb_req", 64'(tlb_req), 64'(est == 2'b01));
        chk(rsp_cca == ecca, "R12", "cache attribute", 64'(rsp_cca), 64'(ecca));
      end
    end else if (!rst) begin
      chk(!tlb_req, "R11", "tlb_req without valid", 64'(tlb_req), 64'h0);
    end
  end

  function automatic logic [31:0] seg_addr(input int s);
    case (s)
      0: return 32'hE000_1234;
      1: return 32'hC000_1234;
      2: return 32'hA000_1234;
      3: return 32'h8000_1234;
      4: return 32'h4000_1234;
      default: return 32'h0000_1234;
    endcase
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] h [6];
    logic [31:0] c0, c1, c2;
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_priv = '0;
    seg_cfg0 = '0; seg_cfg1 = '0; seg_cfg2 = '0;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !tlb_req, "R1", "valid/tlb in reset", 64'({rsp_valid, tlb_req}), 64'h0);
    chk(rsp_status == 2'b00 && rsp_paddr == '0, "R1", "status/paddr in reset",
        64'(rsp_paddr), 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rsp_valid && !tlb_req, "R1", "idle after reset", 64'({rsp_valid, tlb_req}), 64'h0);

    // sweep every privilege, mode and override bit in a wide and a narrow segment
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 8; m++) begin
        for (int e = 0; e < 2; e++) begin
          logic [15:0] d;
          string tg;
          d = mk(7'h55, 3'(m), 1'(e), 3'(m));
          if (p == 3) tg = "R7";
          else if (m == 6) tg = "R8";
          else if (p == 0) tg = "R4";
          else if (p == 1) tg = "R5";
          else tg = "R6";
          send(2'(p), 32'h1234_5678, {d, d}, {d, d}, {d, d}, tg);
          send(2'(p), 32'hA123_4567, {d, d}, {d, d}, {d, d}, tg);
        end
      end
    end

    // selection: distinct base per half, every segment unmapped, kernel
    for (int s = 0; s < 6; s++) h[s] = mk(7'(7'h11 + 13 * s), 3'd7, 1'b0, 3'(s));
    c0 = {h[1], h[0]}; c1 = {h[3], h[2]}; c2 = {h[5], h[4]};
    foreach (h[s]) send(2'd0, seg_addr(s), c0, c1, c2, "R3");
    send(2'd0, 32'h3FFF_FFFF, c0, c1, c2, "R3");
    send(2'd0, 32'h7FFF_FFFF, c0, c1, c2, "R3");
    send(2'd0, 32'h9FFF_FFFF, c0, c1, c2, "R3");
    send(2'd0, 32'hBFFF_FFFF, c0, c1, c2, "R3");
    send(2'd0, 32'hDFFF_FFFF, c0, c1, c2, "R3");
    send(2'd0, 32'hFFFF_FFFF, c0, c1, c2, "R3");

    // selection by mode: one open segment, the rest error for user
    for (int t = 0; t < 6; t++) begin
      for (int s = 0; s < 6; s++) h[s] = mk(7'h7F, (s == t) ? 3'd7 : 3'd0, 1'b0, 3'd2);
      c0 = {h[1], h[0]}; c1 = {h[3], h[2]}; c2 = {h[5], h[4]};
      for (int s = 0; s < 6; s++) send(2'd2, seg_addr(s) ^ 32'h0000_0F0F, c0, c1, c2, "R3");
    end

    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(q_st.size() == 0, "R2", "responses outstanding", 64'(q_st.size()), 64'h0);
    chk(!rsp_valid, "R2", "valid after idle", 64'(rsp_valid), 64'h0);
    done = 1'b1;
    finish_run();
  end
endmodule